// File: doc/BRIEF.md
# Input Rate Tracking Clock Controller

This block makes a local programmable oscillator follow the rate of an incoming audio bit clock. It runs on a stable reference clock. It counts bit-clock rising edges over a fixed gate of reference cycles. From that count it produces a frequency control word, which the oscillator programming logic outside the block consumes.

After the first valid measurement the block issues one coarse word. From then on it runs as a slow first-order digital loop. A per-gate error is formed from three terms: the measured rate, the word currently issued, and a trim that pushes the sample FIFO toward half full. This error is smoothed by a shift-based IIR filter. A new word is issued only when the smoothed error leaves a deadband, and every tracked word is clamped to a narrow window around the coarse setting so the oscillator can retune without glitches. A sticky `locked` flag reports settled tracking. A gate with no bit-clock edges sends the block back to acquisition.

The word leaves on a valid/ready stream. The word and `word_valid` hold until the consumer raises `word_ready`. While a word is pending, the block computes no new word, and the next update comes from a later gate. The `locked` output is a plain status pin.

Top module: `rate_track_ctrl`

## Requirements
- R1: During and after reset, `freq_word` is 0 and `word_valid` and `locked` are 0.
- R2: After reset or after loss of the bit clock, the first complete gate is discarded. The next gate with a nonzero edge count N issues the coarse word N shifted left by FRAC_BITS. This value also becomes the coarse reference.
- R3: While `word_valid` is 1 and `word_ready` is 0, `freq_word` and `word_valid` stay unchanged. `word_valid` falls on the cycle after a transfer with `word_ready` 1.
- R4: While tracking, each gate forms error = (N << FRAC_BITS) - freq_word + ((fill_level - 2^(FILL_W-1)) << TRIM_SHIFT). The filter state then moves by (error - state) >>> FILT_SHIFT.
- R5: A tracked word is issued only when the magnitude of the filtered error is at least DEADBAND. The filter state is cleared after each issued word. A steady small error produces no new word.
- R6: Every tracked word lies within coarse ± (coarse >> SLEW_SHIFT). A larger correction is clamped to that bound.
- R7: With the bit rate matched, a fill level above half raises the word, so the FIFO drains faster.
- R8: `locked` rises once tracking has seen 3 consecutive gates whose raw error magnitude is below DEADBAND. It then stays high until the bit clock is lost.
- R9: A gate with zero bit-clock edges clears `locked` and returns the block to acquisition (R2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk | input | 1 | Incoming audio bit clock, asynchronous |
| fill_level | input | FILL_W | Sample FIFO fill level |
| word_ready | input | 1 | Consumer accepts the frequency word |
| freq_word | output | CNT_W+FRAC_BITS | Frequency control word |
| word_valid | output | 1 | Frequency word is valid |
| locked | output | 1 | Tracking has settled |

## Verification
The checker enforces four rules on every cycle:
- The word is held stable under back-pressure.
- Every tracked word stays inside the slew window around the coarse reference.
- `locked` is only high while tracking.
- `locked` only falls after a gate with no edges.

Other behaviours can only be shown by the bench's scenarios with controlled bit-clock periods and fill levels. These are the exact coarse value, the silence of the deadband under a small steady trim, the direction of the fill-level correction, the three-gate lock qualification, and reacquisition after the bit clock stops.

// File: rtl/rt_pkg.sv
package rt_pkg;
  typedef enum logic [1:0] {
    ST_ACQ    = 2'd0,
    ST_COARSE = 2'd1,
    ST_TRACK  = 2'd2
  } rt_state_e;
endpackage

// File: rtl/rt_edge_counter.sv
module rt_edge_counter #(
  parameter int GATE_CYCLES = 2048,
  parameter int CNT_W       = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bclk,
  output logic [CNT_W-1:0] meas,
  output logic             meas_valid
);
  localparam int GW = $clog2(GATE_CYCLES);

  logic [2:0]       sync_q;
  logic [GW-1:0]    gate_q;
  logic [CNT_W-1:0] edges_q;
  logic             rise;
  logic             gate_end;

  assign rise     = sync_q[1] & ~sync_q[2];
  assign gate_end = (gate_q == GW'(GATE_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q     <= '0;
      gate_q     <= '0;
      edges_q    <= '0;
      meas       <= '0;
      meas_valid <= 1'b0;
    end else begin
      sync_q     <= {sync_q[1:0], bclk};
      meas_valid <= gate_end;
      if (gate_end) begin
        gate_q  <= '0;
        meas    <= edges_q + CNT_W'(rise);
        edges_q <= '0;
      end else begin
        gate_q  <= gate_q + 1'b1;
        edges_q <= edges_q + CNT_W'(rise);
      end
    end
  end
endmodule

// File: rtl/rt_loop_filter.sv
module rt_loop_filter #(
  parameter int CNT_W       = 16,
  parameter int FRAC_BITS   = 20,
  parameter int FILL_W      = 8,
  parameter int FILT_SHIFT  = 4,
  parameter int TRIM_SHIFT  = 8,
  parameter int DEADBAND    = 16384,
  localparam int WORD_W     = CNT_W + FRAC_BITS,
  localparam int EW         = WORD_W + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 meas_valid,
  input  logic [CNT_W-1:0]     meas,
  input  logic [WORD_W-1:0]    cur_word,
  input  logic [FILL_W-1:0]    fill_level,
  output logic signed [EW-1:0] ef,
  output logic                 ef_vld,
  output logic                 ef_big,
  output logic                 err_inband
);
  localparam logic [FILL_W:0] MID = (FILL_W+1)'(1) << (FILL_W - 1);
  localparam logic signed [EW-1:0] DB = EW'(DEADBAND);

  logic signed [EW-1:0]   meas_s, word_s, trim_s, err, ef_n, err_abs, ef_abs;
  logic signed [FILL_W:0] fdiff;

  assign meas_s  = $signed({2'b00, meas, {FRAC_BITS{1'b0}}});
  assign word_s  = $signed({2'b00, cur_word});
  assign fdiff   = $signed({1'b0, fill_level}) - $signed(MID);
  assign trim_s  = EW'(fdiff) <<< TRIM_SHIFT;
  assign err     = meas_s - word_s + trim_s;
  assign ef_n    = ef + ((err - ef) >>> FILT_SHIFT);
  assign err_abs = err[EW-1] ? -err : err;
  assign ef_abs  = ef_n[EW-1] ? -ef_n : ef_n;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      ef         <= '0;
      ef_vld     <= 1'b0;
      ef_big     <= 1'b0;
      err_inband <= 1'b0;
    end else begin
      ef_vld <= meas_valid;
      if (meas_valid) begin
        ef         <= ef_n;
        ef_big     <= (ef_abs >= DB);
        err_inband <= (err_abs < DB);
      end
    end
  end
endmodule

// File: rtl/rate_track_ctrl.sv
module rate_track_ctrl #(
  parameter int GATE_CYCLES = 2048,
  parameter int CNT_W       = 16,
  parameter int FRAC_BITS   = 20,
  parameter int FILL_W      = 8,
  parameter int FILT_SHIFT  = 4,
  parameter int TRIM_SHIFT  = 8,
  parameter int DEADBAND    = 16384,
  parameter int SLEW_SHIFT  = 10,
  parameter int LOCK_GATES  = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bclk,
  input  logic [FILL_W-1:0]          fill_level,
  input  logic                       word_ready,
  output logic [CNT_W+FRAC_BITS-1:0] freq_word,
  output logic                       word_valid,
  output logic                       locked
);
  import rt_pkg::*;
  localparam int WORD_W = CNT_W + FRAC_BITS;
  localparam int EW     = WORD_W + 2;
  localparam int LCW    = $clog2(LOCK_GATES + 1);

  rt_state_e            state_q;
  logic [WORD_W-1:0]    coarse_q;
  logic [LCW-1:0]       lock_cnt_q;
  logic [CNT_W-1:0]     meas;
  logic                 meas_valid;
  logic signed [EW-1:0] ef;
  logic                 ef_vld, ef_big, err_inband;
  logic                 pending, issue, filt_clr;
  logic signed [EW-1:0] cand, lim, hi, lo, clamped;

  rt_edge_counter #(.GATE_CYCLES(GATE_CYCLES), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .meas(meas), .meas_valid(meas_valid)
  );

  rt_loop_filter #(
    .CNT_W(CNT_W), .FRAC_BITS(FRAC_BITS), .FILL_W(FILL_W), .FILT_SHIFT(FILT_SHIFT),
    .TRIM_SHIFT(TRIM_SHIFT), .DEADBAND(DEADBAND)
  ) u_filt (
    .clk(clk), .rst_n(rst_n), .clr(filt_clr), .meas_valid(meas_valid), .meas(meas),
    .cur_word(freq_word), .fill_level(fill_level), .ef(ef), .ef_vld(ef_vld),
    .ef_big(ef_big), .err_inband(err_inband)
  );

  assign pending  = word_valid && !word_ready;
  assign lim      = $signed({2'b00, coarse_q >> SLEW_SHIFT});
  assign hi       = $signed({2'b00, coarse_q}) + lim;
  assign lo       = $signed({2'b00, coarse_q}) - lim;
  assign cand     = $signed({2'b00, freq_word}) + ef;
  assign clamped  = (cand > hi) ? hi : ((cand < lo) ? lo : cand);
  assign issue    = (state_q == ST_TRACK) && ef_vld && ef_big && !pending &&
                    (clamped != $signed({2'b00, freq_word}));
  assign filt_clr = (state_q != ST_TRACK) || (ef_vld && ef_big && !pending);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_ACQ;
      coarse_q   <= '0;
      lock_cnt_q <= '0;
      freq_word  <= '0;
      word_valid <= 1'b0;
      locked     <= 1'b0;
    end else begin
      if (word_valid && word_ready) word_valid <= 1'b0;
      if (meas_valid && meas == '0) begin
        state_q    <= ST_ACQ;
        locked     <= 1'b0;
        lock_cnt_q <= '0;
      end else begin
        case (state_q)
          ST_ACQ: if (meas_valid) state_q <= ST_COARSE;
          ST_COARSE: if (meas_valid && !pending) begin
            coarse_q   <= {meas, {FRAC_BITS{1'b0}}};
            freq_word  <= {meas, {FRAC_BITS{1'b0}}};
            word_valid <= 1'b1;
            lock_cnt_q <= '0;
            state_q    <= ST_TRACK;
          end
          ST_TRACK: begin
            if (ef_vld) begin
              if (!err_inband) lock_cnt_q <= '0;
              else if (lock_cnt_q < LCW'(LOCK_GATES)) begin
                lock_cnt_q <= lock_cnt_q + 1'b1;
                if (lock_cnt_q == LCW'(LOCK_GATES - 1)) locked <= 1'b1;
              end
            end
            if (issue) begin
              freq_word  <= clamped[WORD_W-1:0];
              word_valid <= 1'b1;
            end
          end
          default: state_q <= ST_ACQ;
        endcase
      end
    end
  end
endmodule

// File: rtl/rt_chk.sv
module rt_chk #(
  parameter int WORD_W     = 36,
  parameter int CNT_W      = 16,
  parameter int SLEW_SHIFT = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic [WORD_W-1:0] freq_word,
  input logic              word_valid,
  input logic              word_ready,
  input logic              locked,
  input logic [1:0]        state_q,
  input logic [WORD_W-1:0] coarse_q,
  input logic              meas_valid,
  input logic [CNT_W-1:0]  meas
);
  logic [WORD_W:0] hi_w, lo_w;
  assign hi_w = {1'b0, coarse_q} + {1'b0, coarse_q >> SLEW_SHIFT};
  assign lo_w = {1'b0, coarse_q} - {1'b0, coarse_q >> SLEW_SHIFT};

  // R3
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && !word_ready) |=> (word_valid && $stable(freq_word)));

  // R6
  slew_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == 2'd2) |-> ({1'b0, freq_word} <= hi_w && {1'b0, freq_word} >= lo_w));

  // R8
  lock_in_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> (state_q == 2'd2));

  // R9
  unlock_on_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> $past(meas_valid && meas == '0));
endmodule

bind rate_track_ctrl rt_chk #(
  .WORD_W(CNT_W + FRAC_BITS), .CNT_W(CNT_W), .SLEW_SHIFT(SLEW_SHIFT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .freq_word(freq_word), .word_valid(word_valid),
  .word_ready(word_ready), .locked(locked), .state_q(state_q), .coarse_q(coarse_q),
  .meas_valid(meas_valid), .meas(meas)
);

// File: tb/sim_rate_track_ctrl.sv
`timescale 1ns/1ps
module sim_rate_track_ctrl;
  localparam int GATE  = 2048;
  localparam int CNT_W = 16;
  localparam int FRAC  = 20;
  localparam int FW    = 8;
  localparam int DB    = 16384;
  localparam int WW    = CNT_W + FRAC;
  localparam longint COARSE = longint'(256) << FRAC;
  localparam longint LIMIT  = COARSE >> 10;

  logic          clk = 0, rst_n = 0, bclk = 0, word_ready = 1;
  logic [FW-1:0] fill_level = 8'd128;
  logic [WW-1:0] freq_word;
  logic          word_valid, locked;
  logic          bclk_en = 0;
  int            bhalf = 40;
  int            checks = 0, errors = 0, accepted = 0;

  rate_track_ctrl #(
    .GATE_CYCLES(GATE), .CNT_W(CNT_W), .FRAC_BITS(FRAC), .FILL_W(FW), .FILT_SHIFT(2),
    .TRIM_SHIFT(8), .DEADBAND(DB), .SLEW_SHIFT(10), .LOCK_GATES(3)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .fill_level(fill_level),
    .word_ready(word_ready), .freq_word(freq_word), .word_valid(word_valid), .locked(locked)
  );

  always #5 clk = ~clk;

  initial begin
    #2;
    forever begin
      if (bclk_en) begin #(bhalf) bclk = ~bclk; end
      else begin bclk = 0; #10; end
    end
  end

  always @(posedge clk) if (rst_n && word_valid && word_ready) accepted <= accepted + 1;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic gates(input int n);
    repeat (n * GATE) @(posedge clk);
    #1;
  endtask

  task automatic wait_word(input int max_gates, output bit got);
    int start;
    start = accepted;
    got = 0;
    for (int i = 0; i < max_gates * GATE; i++) begin
      @(posedge clk);
      if (accepted != start) begin got = 1; break; end
    end
    #1;
  endtask

  task automatic t_reset();
    repeat (4) @(posedge clk);
    #1;
    chk(freq_word == 0, "R1 word", freq_word, 0);
    chk(!word_valid, "R1 valid", word_valid, 0);
    chk(!locked, "R1 locked", locked, 0);
    rst_n = 1;
  endtask

  task automatic t_coarse();
    bit got;
    bclk_en = 1;
    wait_word(4, got);
    chk(got, "R2 coarse issued", got, 1);
    chk(freq_word == COARSE, "R2 coarse value", freq_word, COARSE);
  endtask

  task automatic t_lock();
    int a0;
    a0 = accepted;
    gates(5);
    chk(locked, "R8 locked after in-band gates", locked, 1);
    chk(accepted == a0, "R5 no word when matched", accepted - a0, 0);
  endtask

  task automatic t_deadband();
    int a0;
    fill_level = 8'd136;
    a0 = accepted;
    gates(8);
    chk(accepted == a0, "R5 small trim stays in deadband", accepted - a0, 0);
    chk(freq_word == COARSE, "R5 word unchanged", freq_word, COARSE);
    chk(locked, "R8 locked sticky", locked, 1);
  endtask

  task automatic t_trim();
    bit got;
    longint d;
    fill_level = 8'd228;
    wait_word(10, got);
    d = longint'(freq_word) - COARSE;
    chk(got, "R4 trim word issued", got, 1);
    chk(d >= DB && d <= 25600, "R7 word raised by filtered trim", d, DB);
    fill_level = 8'd128;
    gates(6);
  endtask

  task automatic t_slew();
    bhalf = 32;
    gates(10);
    chk(freq_word == COARSE + LIMIT, "R6 clamped to upper bound", freq_word, COARSE + LIMIT);
  endtask

  task automatic t_loss();
    bclk_en = 0;
    gates(3);
    chk(!locked, "R9 unlock on missing bclk", locked, 0);
  endtask

  task automatic t_stall();
    longint w;
    word_ready = 0;
    bhalf = 40;
    bclk_en = 1;
    for (int i = 0; i < 5 * GATE && !word_valid; i++) @(posedge clk);
    #1;
    chk(word_valid, "R2 reacquire issues word", word_valid, 1);
    chk(freq_word == COARSE, "R2 reacquired coarse", freq_word, COARSE);
    w = freq_word;
    repeat (50) @(posedge clk);
    #1;
    chk(word_valid && freq_word == w, "R3 held under stall", freq_word, w);
    word_ready = 1;
    @(posedge clk);
    #1;
    chk(!word_valid, "R3 valid drops after transfer", word_valid, 0);
  endtask

  initial begin
    #(150000 * 10);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_coarse();
    t_lock();
    t_deadband();
    t_trim();
    t_slew();
    t_loss();
    t_stall();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule